// File: doc/BRIEF.md
# Video Power Domain Sequencer

This block is a hardware state machine that brings a video-processing power domain up or takes it down in answer to single-cycle on and off requests. It drives the domain's power-switch control, its isolation control, three banks of memory power-down bits, a domain reset and a clock enable. Between steps it waits a programmable number of microseconds. The wait is counted with a prescaler that turns the system clock into microsecond ticks.

Power-up removes the domain power-down first. Then it releases the memories one small group at a time, with a settle wait after each group. Resets are asserted around the removal of isolation, and the clocks are turned on last. Power-down asserts isolation first and gates the memories in the same group order. It then cuts the domain power and holds a long final wait before turning the clocks off. A pulse on `done` marks the end of every accepted request. `busy` covers the whole sequence.

Top module: `vdom_pwr_seq`

## Requirements
- R1: After reset the domain is off: `pwr_dn`=1, `iso_en`=1, every memory bit is 1, `dom_rst`=1, `clk_en`=0, `busy`=0 and `done`=0.
- R2: An `on_req` accepted while idle with the domain off drops `pwr_dn` and raises `busy` at the next clock edge. The first memory group is released LEAD_US microseconds after that edge.
- R3: Power-up clears memory bits in this order: bank A in 2-bit pairs from bits [1:0] upward, then bank B in the same way, then the auxiliary bank one bit at a time from its bit 0 (the domain's bit 8) to its bit 7 (bit 15). That makes 40 steps, STEP_US apart. Only one group changes per step, and no bit is set. A memory bit of 1 means powered down.
- R4: STEP_US+SETTLE_US after the last power-up step, `dom_rst` is asserted. One cycle later `iso_en` falls. One cycle after that `dom_rst` falls. One cycle later `clk_en` rises, `done` pulses for one cycle and `busy` falls.
- R5: An `off_req` accepted while idle with the domain on raises `iso_en` at the next edge. LEAD_US later the memory bits start to be set, in the same order, grouping and spacing as R3, and no bit is cleared.
- R6: STEP_US+SETTLE_US after the last power-down step, `pwr_dn` rises. OFF_US later `clk_en` falls, `done` pulses for one cycle and `busy` falls. `dom_rst` is left unchanged.
- R7: `on_req` and `off_req` have no effect while `busy` is high.
- R8: A request that matches the present domain state leaves every output unchanged, keeps `busy` low and pulses `done` at the next edge.
- R9: If `on_req` and `off_req` are both high in the same idle cycle, `on_req` takes priority.
- R10: A wait of N microseconds lasts exactly N×TICK_DIV clock cycles, counted from the edge that starts it.
- R11: `iso_en` is low only while `pwr_dn` is low, and `clk_en` rises only while `iso_en` and `dom_rst` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| on_req | input | 1 | Power-up request, sampled in idle |
| off_req | input | 1 | Power-down request, sampled in idle |
| pwr_dn | output | 1 | Domain power-switch off control, active high |
| iso_en | output | 1 | Domain output isolation, active high |
| mem_pd_a | output | WORD_W | Memory bank A power-down bits, 1 = off |
| mem_pd_b | output | WORD_W | Memory bank B power-down bits, 1 = off |
| mem_pd_c | output | AUX_HI-AUX_LO+1 | Auxiliary memory power-down bits (domain bits AUX_LO..AUX_HI), 1 = off |
| dom_rst | output | 1 | Domain reset, active high |
| clk_en | output | 1 | Domain clock enable |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The bench builds the block with TICK_DIV=2, the default 20/5/20 microsecond lead, step and settle waits, and OFF_US shortened to 40. With these values a full power-up takes 483 cycles and a power-down 560. That makes it practical to compare every output against a cycle-exact model on every cycle of many sequences. At TICK_DIV=2 the prescaler wraps and a wait restarts on the same edge it expires, so an off-by-one in either shows up as a one-cycle shift. The random mix adds stray and simultaneous requests during and between sequences.

// File: rtl/vdom_pkg.sv
package vdom_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_MEMW,
    S_SETTLE,
    S_RST_ON,
    S_ISO_OFF,
    S_RST_OFF,
    S_OFFW
  } seq_state_t;

  function automatic int vdom_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vdom_tick.sv
module vdom_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == PW'(DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/vdom_delay.sv
module vdom_delay #(
  parameter int DIV = 100,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] len_us,
  output logic          expire
);
  logic          active_q, active_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          us_tick;
  logic          pre_clr;

  assign pre_clr = start || !active_q;

  vdom_tick #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pre_clr),
    .tick  (us_tick)
  );

  assign expire = active_q && us_tick && (cnt_q == DW'(1));

  always_comb begin
    cnt_d    = cnt_q;
    active_d = active_q;
    if (start) begin
      cnt_d    = len_us;
      active_d = 1'b1;
    end else if (expire) begin
      cnt_d    = '0;
      active_d = 1'b0;
    end else if (active_q && us_tick) begin
      cnt_d = cnt_q - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
    end
  end

  // R10: a wait is never loaded with zero length
  a_r10_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (len_us != '0));

  // R10: a new wait only starts when none is running or the current one ends
  a_r10_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!active_q || expire));

endmodule

// File: rtl/vdom_memgate.sv
module vdom_memgate #(
  parameter int WORD_W = 32,
  parameter int GRP_W  = 2,
  parameter int AUX_LO = 8,
  parameter int AUX_HI = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step,
  input  logic                     set_dir,
  output logic [WORD_W-1:0]        w_a,
  output logic [WORD_W-1:0]        w_b,
  output logic [AUX_HI-AUX_LO:0]   w_c,
  output logic                     at_start
);
  localparam int NG    = WORD_W / GRP_W;
  localparam int NA    = AUX_HI - AUX_LO + 1;
  localparam int NSTEP = 2 * NG + NA;
  localparam int IW    = $clog2(NSTEP);
  localparam int TOT   = 2 * WORD_W + NA;
  localparam logic [WORD_W-1:0] GMASK = {{(WORD_W-GRP_W){1'b0}}, {GRP_W{1'b1}}};
  localparam logic [NA-1:0]     AONE  = {{(NA-1){1'b0}}, 1'b1};

  logic [IW-1:0]     idx_q, idx_d;
  logic              last;
  int                idx_i;
  logic [WORD_W-1:0] mask_w [2];
  logic [WORD_W-1:0] word_q [2];
  logic [NA-1:0]     mask_c;
  logic [NA-1:0]     aux_q;
  logic [TOT-1:0]    all_w;

  assign idx_i    = int'(idx_q);
  assign last     = (idx_q == IW'(NSTEP - 1));
  assign at_start = (idx_q == '0);

  always_comb begin
    mask_w[0] = '0;
    mask_w[1] = '0;
    mask_c    = '0;
    if (idx_i < NG) begin
      mask_w[0] = GMASK << (idx_i * GRP_W);
    end else if (idx_i < 2 * NG) begin
      mask_w[1] = GMASK << ((idx_i - NG) * GRP_W);
    end else begin
      mask_c = AONE << (idx_i - 2 * NG);
    end
  end

  always_comb begin
    idx_d = idx_q;
    if (step) begin
      idx_d = last ? '0 : idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (step) begin
      idx_q <= idx_d;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '1;
      end else if (step) begin
        word_q[g] <= set_dir ? (word_q[g] | mask_w[g]) : (word_q[g] & ~mask_w[g]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q <= '1;
    end else if (step) begin
      aux_q <= set_dir ? (aux_q | mask_c) : (aux_q & ~mask_c);
    end
  end

  assign w_a   = word_q[0];
  assign w_b   = word_q[1];
  assign w_c   = aux_q;
  assign all_w = {word_q[0], word_q[1], aux_q};

  // R3: memory bits move only on a step
  a_r3_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(all_w));

  // R3: one group at most changes per step
  a_r3_one_group: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ($countones(all_w ^ $past(all_w)) <= GRP_W));

  // R3: power-up steps never set a bit
  a_r3_release_only: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !set_dir) |=> ((all_w & ~$past(all_w)) == '0));

  // R5: power-down steps never clear a bit
  a_r5_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    (step && set_dir) |=> ((~all_w & $past(all_w)) == '0));

endmodule

// File: rtl/vdom_fsm.sv
module vdom_fsm
  import vdom_pkg::*;
#(
  parameter int DW        = 16,
  parameter int LEAD_US   = 20,
  parameter int STEP_US   = 5,
  parameter int SETTLE_US = 20,
  parameter int OFF_US    = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_req,
  input  logic          off_req,
  input  logic          dly_exp,
  input  logic          mem_at_start,
  output logic          dly_start,
  output logic [DW-1:0] dly_len,
  output logic          mem_step,
  output logic          mem_set,
  output logic          pwr_dn,
  output logic          iso_en,
  output logic          dom_rst,
  output logic          clk_en,
  output logic          busy,
  output logic          done
);
  seq_state_t state_q, state_d;
  logic dir_q, dir_d;
  logic on_q, on_d;
  logic pwr_q, pwr_d;
  logic iso_q, iso_d;
  logic rst_q, rst_d;
  logic clk_q, clk_d;
  logic done_q, done_d;

  always_comb begin
    state_d   = state_q;
    dir_d     = dir_q;
    on_d      = on_q;
    pwr_d     = pwr_q;
    iso_d     = iso_q;
    rst_d     = rst_q;
    clk_d     = clk_q;
    done_d    = 1'b0;
    dly_start = 1'b0;
    dly_len   = '0;
    mem_step  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (on_req) begin
          if (on_q) begin
            done_d = 1'b1;
          end else begin
            dir_d     = 1'b0;
            pwr_d     = 1'b0;
            dly_start = 1'b1;
            dly_len   = DW'(LEAD_US);
            state_d   = S_LEAD;
          end
        end else if (off_req) begin
          if (!on_q) begin
            done_d = 1'b1;
          end else begin
            dir_d     = 1'b1;
            iso_d     = 1'b1;
            dly_start = 1'b1;
            dly_len   = DW'(LEAD_US);
            state_d   = S_LEAD;
          end
        end
      end
      S_LEAD: begin
        if (dly_exp) begin
          mem_step  = 1'b1;
          dly_start = 1'b1;
          dly_len   = DW'(STEP_US);
          state_d   = S_MEMW;
        end
      end
      S_MEMW: begin
        if (dly_exp) begin
          dly_start = 1'b1;
          if (mem_at_start) begin
            dly_len = DW'(SETTLE_US);
            state_d = S_SETTLE;
          end else begin
            mem_step = 1'b1;
            dly_len  = DW'(STEP_US);
          end
        end
      end
      S_SETTLE: begin
        if (dly_exp) begin
          if (dir_q) begin
            pwr_d     = 1'b1;
            dly_start = 1'b1;
            dly_len   = DW'(OFF_US);
            state_d   = S_OFFW;
          end else begin
            rst_d   = 1'b1;
            state_d = S_RST_ON;
          end
        end
      end
      S_RST_ON: begin
        iso_d   = 1'b0;
        state_d = S_ISO_OFF;
      end
      S_ISO_OFF: begin
        rst_d   = 1'b0;
        state_d = S_RST_OFF;
      end
      S_RST_OFF: begin
        clk_d   = 1'b1;
        on_d    = 1'b1;
        done_d  = 1'b1;
        state_d = S_IDLE;
      end
      S_OFFW: begin
        if (dly_exp) begin
          clk_d   = 1'b0;
          on_d    = 1'b0;
          done_d  = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dir_q   <= 1'b0;
      on_q    <= 1'b0;
      pwr_q   <= 1'b1;
      iso_q   <= 1'b1;
      rst_q   <= 1'b1;
      clk_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      on_q    <= on_d;
      pwr_q   <= pwr_d;
      iso_q   <= iso_d;
      rst_q   <= rst_d;
      clk_q   <= clk_d;
      done_q  <= done_d;
    end
  end

  assign mem_set = dir_q;
  assign pwr_dn  = pwr_q;
  assign iso_en  = iso_q;
  assign dom_rst = rst_q;
  assign clk_en  = clk_q;
  assign busy    = (state_q != S_IDLE);
  assign done    = done_q;

  // R11: isolation is lifted only while the domain is powered
  a_r11_iso_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    !iso_q |-> !pwr_q);

  // R11: clocks come on only with isolation off and resets released
  a_r11_clk_on_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |-> (!iso_q && !rst_q));

  // R6: clocks stop only after the switch is off
  a_r6_clk_off_after_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_q) |-> pwr_q);

  // R8: completion is reported only when back in idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == S_IDLE));

  // R2: no sequence starts without a request
  a_r2_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_IDLE) && !on_req && !off_req) |=> (state_q == S_IDLE));

endmodule

// File: rtl/vdom_pwr_seq.sv
module vdom_pwr_seq
  import vdom_pkg::*;
#(
  parameter int TICK_DIV  = 100,
  parameter int LEAD_US   = 20,
  parameter int STEP_US   = 5,
  parameter int SETTLE_US = 20,
  parameter int OFF_US    = 20000,
  parameter int WORD_W    = 32,
  parameter int GRP_W     = 2,
  parameter int AUX_LO    = 8,
  parameter int AUX_HI    = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   on_req,
  input  logic                   off_req,
  output logic                   pwr_dn,
  output logic                   iso_en,
  output logic [WORD_W-1:0]      mem_pd_a,
  output logic [WORD_W-1:0]      mem_pd_b,
  output logic [AUX_HI-AUX_LO:0] mem_pd_c,
  output logic                   dom_rst,
  output logic                   clk_en,
  output logic                   busy,
  output logic                   done
);
  localparam int MAX_US = vdom_max(vdom_max(LEAD_US, STEP_US), vdom_max(SETTLE_US, OFF_US));
  localparam int DW     = $clog2(MAX_US + 1);

  logic          rst_meta, rst_core;
  logic          dly_start, dly_exp;
  logic [DW-1:0] dly_len;
  logic          mem_step, mem_set, mem_at_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  vdom_fsm #(
    .DW        (DW),
    .LEAD_US   (LEAD_US),
    .STEP_US   (STEP_US),
    .SETTLE_US (SETTLE_US),
    .OFF_US    (OFF_US)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_core),
    .on_req       (on_req),
    .off_req      (off_req),
    .dly_exp      (dly_exp),
    .mem_at_start (mem_at_start),
    .dly_start    (dly_start),
    .dly_len      (dly_len),
    .mem_step     (mem_step),
    .mem_set      (mem_set),
    .pwr_dn       (pwr_dn),
    .iso_en       (iso_en),
    .dom_rst      (dom_rst),
    .clk_en       (clk_en),
    .busy         (busy),
    .done         (done)
  );

  vdom_delay #(
    .DIV (TICK_DIV),
    .DW  (DW)
  ) u_delay (
    .clk    (clk),
    .rst_n  (rst_core),
    .start  (dly_start),
    .len_us (dly_len),
    .expire (dly_exp)
  );

  vdom_memgate #(
    .WORD_W (WORD_W),
    .GRP_W  (GRP_W),
    .AUX_LO (AUX_LO),
    .AUX_HI (AUX_HI)
  ) u_mem (
    .clk      (clk),
    .rst_n    (rst_core),
    .step     (mem_step),
    .set_dir  (mem_set),
    .w_a      (mem_pd_a),
    .w_b      (mem_pd_b),
    .w_c      (mem_pd_c),
    .at_start (mem_at_start)
  );

endmodule

// File: tb/test_vdom_pwr_seq.sv
module test_vdom_pwr_seq;
  localparam int DIV  = 2;
  localparam int LEAD = 20;
  localparam int STEP = 5;
  localparam int SETL = 20;
  localparam int OFFW = 40;
  localparam int NG   = 16;
  localparam int NA   = 8;
  localparam int NST  = 2 * NG + NA;
  localparam int LD   = LEAD * DIV;
  localparam int SD   = STEP * DIV;
  localparam int EDG  = LD + NST * SD + SETL * DIV;

  logic clk = 1'b0;
  logic rst_n;
  logic on_req, off_req;
  logic pwr_dn, iso_en, dom_rst, clk_en, busy, done;
  logic [31:0] mem_pd_a, mem_pd_b;
  logic [7:0]  mem_pd_c;

  int n_chk = 0;
  int n_err = 0;
  bit m_on  = 1'b0;
  bit m_rst = 1'b1;

  always #5 clk = ~clk;

  vdom_pwr_seq #(
    .TICK_DIV (DIV), .LEAD_US (LEAD), .STEP_US (STEP),
    .SETTLE_US (SETL), .OFF_US (OFFW)
  ) i_vdom_pwr_seq (
    .clk (clk), .rst_n (rst_n), .on_req (on_req), .off_req (off_req),
    .pwr_dn (pwr_dn), .iso_en (iso_en), .mem_pd_a (mem_pd_a),
    .mem_pd_b (mem_pd_b), .mem_pd_c (mem_pd_c), .dom_rst (dom_rst),
    .clk_en (clk_en), .busy (busy), .done (done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected bits of a bank: groups first..first+n-1, g bits each, after k steps
  function automatic logic [31:0] exp_bank(int first, int k, int n, int g, bit pd);
    logic [31:0] v = '0;
    for (int b = 0; b < n * g; b++) begin
      v[b] = (first + b / g < k) ? pd : !pd;
    end
    return v;
  endfunction

  function automatic logic [5:0] ctrl_now();
    return {pwr_dn, iso_en, dom_rst, clk_en, busy, done};
  endfunction

  function automatic logic [5:0] ctrl_idle();
    return {!m_on, !m_on, m_rst, m_on, 1'b0, 1'b0};
  endfunction

  task automatic chk_idle_words(input string tag);
    chk({tag, " bank A"}, mem_pd_a, m_on ? 32'h0 : 32'hFFFF_FFFF);
    chk({tag, " bank B"}, mem_pd_b, m_on ? 32'h0 : 32'hFFFF_FFFF);
    chk({tag, " bank C"}, {24'h0, mem_pd_c}, m_on ? 32'h0 : 32'hFF);
  endtask

  // full sequence; pd selects power-down, both raises both requests (R9)
  task automatic run_seq(input bit pd, input bit both);
    int endt = pd ? EDG + OFFW * DIV : EDG + 3;
    int seen = -1;
    string tg;
    @(negedge clk);
    on_req  = !pd || both;
    off_req = pd || both;
    for (int t = 0; t <= endt + 1; t++) begin
      int k;
      logic [5:0] ex;
      @(negedge clk);
      k = (t < LD) ? 0 : (((t - LD) / SD + 1 > NST) ? NST : (t - LD) / SD + 1);
      if (pd) begin
        ex = {(t >= EDG), 1'b1, m_rst, (t < endt), (t < endt), (t == endt)};
        tg = (t < LD) ? "R5 lead" : (t < EDG) ? "R5 R10 mem" : "R6 R10 tail";
      end else begin
        ex = {1'b0, (t <= EDG),
              (t >= EDG && t <= EDG + 1) ? 1'b1 : ((t < EDG) ? m_rst : 1'b0),
              (t >= endt), (t < endt), (t == endt)};
        tg = (t < LD) ? (both ? "R9 R2 lead" : "R2 lead") :
             (t < EDG) ? "R3 R10 mem" : "R4 R11 tail";
      end
      if (done && seen < 0) seen = t;
      chk({tg, " ctrl"}, {26'h0, ctrl_now()}, {26'h0, ex});
      chk({tg, " bank A"}, mem_pd_a, exp_bank(0, k, NG, 2, pd));
      chk({tg, " bank B"}, mem_pd_b, exp_bank(NG, k, NG, 2, pd));
      chk({tg, " bank C"}, {24'h0, mem_pd_c}, exp_bank(2 * NG, k, NA, 1, pd));
      on_req  = 1'b0;
      off_req = 1'b0;
      if (t < endt && ($urandom % 6) == 0) begin
        on_req  = $urandom % 2;
        off_req = $urandom % 2;
      end
    end
    chk("R7 R10 completion cycle", seen, endt);
    m_on = !pd;
    if (!pd) m_rst = 1'b0;
  endtask

  task automatic req_match(input bit use_on, input bit use_off);
    @(negedge clk);
    on_req  = use_on;
    off_req = use_off;
    @(negedge clk);
    on_req  = 1'b0;
    off_req = 1'b0;
    chk(use_on && use_off ? "R9 R8 done pulse" : "R8 done pulse",
        {26'h0, ctrl_now()}, {26'h0, ctrl_idle() | 6'b000001});
    chk_idle_words("R8 unchanged");
    @(negedge clk);
    chk("R8 done one cycle", {26'h0, ctrl_now()}, {26'h0, ctrl_idle()});
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R7 idle hold", {26'h0, ctrl_now()}, {26'h0, ctrl_idle()});
    end
    chk_idle_words("R7 idle hold");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog expired act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D0C_5EED));
    rst_n   = 1'b0;
    on_req  = 1'b0;
    off_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {26'h0, ctrl_now()}, {26'h0, 6'b111000});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset state", {26'h0, ctrl_now()}, {26'h0, 6'b111000});
    chk_idle_words("R1 reset");

    req_match(1'b0, 1'b1);   // off while off
    run_seq(1'b0, 1'b0);     // power up
    req_match(1'b1, 1'b0);   // on while on
    req_match(1'b1, 1'b1);   // both while on: on wins, matches
    run_seq(1'b1, 1'b0);     // power down
    run_seq(1'b0, 1'b1);     // both while off: powers up
    run_seq(1'b1, 1'b0);

    for (int it = 0; it < 10; it++) begin
      int r = $urandom % 4;
      if (!m_on) begin
        case (r)
          0: run_seq(1'b0, 1'b0);
          1: run_seq(1'b0, 1'b1);
          2: req_match(1'b0, 1'b1);
          default: gap(1 + $urandom % 8);
        endcase
      end else begin
        case (r)
          0, 1: run_seq(1'b1, 1'b0);
          2: req_match(1'b1, 1'b0);
          default: req_match(1'b1, 1'b1);
        endcase
      end
      gap($urandom % 4);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule